// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects interrupt requests from fourteen peripheral sources and turns them into a 3-bit priority level for the processor. It keeps two registers. The request register holds one pending flag for each source. The enable register holds one enable flag for each source plus a master enable. Software changes individual bits of either register with a set/clear write word, so bits it does not mark are left alone.

Peripherals raise requests by pulsing their line in the `hw_req_i` vector. The request register can be read back at any time. The highest level among sources that are both pending and enabled is placed on a registered level output, provided the master enable is set.

Top module: `irq_level_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the request register, the enable register and `ipl_o` are all zero.
- R2: Writing the request register with bit 15 = 1 sets every request bit whose position in bits 13:0 holds a 1. All other request bits keep their values.
- R3: Writing the request register with bit 15 = 0 clears every request bit whose position in bits 13:0 holds a 1. All other request bits keep their values.
- R4: The enable register uses the same set/clear convention over bits 14:0. Bits 13:0 are the per-source enables and bit 14 is the master enable.
- R5: A 1 on `hw_req_i[i]` sets request bit i at the next clock edge. If software clears that bit in the same cycle, the hardware set wins and the bit ends up 1.
- R6: `req_rd_o` shows the request register in bits 13:0, and bits 15:14 always read 0. Marking bit 14 in a request write has no visible effect.
- R7: Each source has a fixed priority level, as shown below.

  | Sources | Level |
  |---|---|
  | 0–2 | 1 |
  | 3 | 2 |
  | 4–6 | 3 |
  | 7–10 | 4 |
  | 11–12 | 5 |
  | 13 | 6 |

- R8: `ipl_o` is the highest level among sources that are both pending and enabled. It is 0 when no such source exists.
- R9: `ipl_o` is 0 whenever the master enable is clear, regardless of pending and enabled sources.
- R10: `ipl_o` is registered. It reflects the register contents one clock after they change, so a write at edge k shows on `ipl_o` after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_req_i | input | 14 | Per-source request pulses from peripherals |
| req_wr_i | input | 1 | Write strobe for the request register |
| en_wr_i | input | 1 | Write strobe for the enable register |
| wr_data_i | input | 16 | Write word: bit 15 selects set (1) or clear (0), lower bits mark targets |
| req_rd_o | output | 16 | Request register readback |
| ipl_o | output | 3 | Registered CPU interrupt priority level |

## Verification
Directed cases cover the following:
- Each source alone, which pins down every entry of the level map.
- Pairs of sources at different levels, which separate a true highest-level pick from a lowest-bit or highest-bit pick.
- A hardware pulse that collides with a software clear, which exposes the wrong winner.
- Master-off with sources pending and enabled, which shows the master gate.
- A sample taken right after a write, which separates one-cycle latency from none.

A seeded random run then mixes both kinds of write with sparse hardware pulses. It compares the readback and the level each cycle against a bench model, which shows whether unmarked bits really stay unchanged.

// File: rtl/irq_pkg.sv
// Package irq_pkg: shared sizes and the fixed source-to-level map.
// Assumes sources are numbered from 0 and levels run 1..6.
package irq_pkg;
    localparam int NUM_SRC = 14;
    localparam int WORD_W  = 16;
    localparam int LVL_W   = 3;

    // Returns the priority level assigned to source idx.
    function automatic int src_level(input int idx);
        if (idx <= 2)       return 1;
        else if (idx == 3)  return 2;
        else if (idx <= 6)  return 3;
        else if (idx <= 10) return 4;
        else if (idx <= 12) return 5;
        else                return 6;
    endfunction
endpackage

// File: rtl/irq_setclr_reg.sv
// Module irq_setclr_reg: W-bit register written through a set/clear convention.
// A write with set_sel=1 sets the bits marked in mask; with set_sel=0 it clears them.
// hw_set pulses set bits and take precedence over a same-cycle clear.
// Assumes a synchronous active-low reset that brings every bit to 0.
module irq_setclr_reg #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         set_sel,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    logic [W-1:0] q_next;

    // Next-state: apply the software action, then OR in hardware sets.
    always_comb begin
        q_next = q;
        if (wr) begin
            if (set_sel) q_next = q_next | mask;
            else         q_next = q_next & ~mask;
        end
        q_next = q_next | hw_set;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    AST_SET_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && set_sel) |=> ((q & $past(mask)) == $past(mask))); // R2
    AST_CLEAR_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !set_sel) |=> ((q & $past(mask & ~hw_set)) == '0)); // R3
    AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set))); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && hw_set == '0) |=> $stable(q)); // R4
endmodule

// File: rtl/irq_prio_enc.sv
// Module irq_prio_enc: combinational encoder from active sources to the highest level.
// Assumes the level map in irq_pkg; the result is 0 when no source is active.
module irq_prio_enc #(
    parameter int NUM_SRC = 14,
    parameter int LVL_W   = 3
) (
    input  logic [NUM_SRC-1:0] active,
    output logic [LVL_W-1:0]   level
);
    import irq_pkg::*;

    // Scan all sources and keep the maximum level among active ones.
    always_comb begin
        level = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (active[i] && (src_level(i) > int'(level)))
                level = LVL_W'(src_level(i));
        end
    end
endmodule

// File: rtl/irq_level_ctrl.sv
// Module irq_level_ctrl: top-level interrupt request controller.
// It holds the request and enable registers, gates them with the master enable
// and registers the encoded CPU priority level.
// Assumes NUM_SRC + 1 < WORD_W: the master enable sits at bit NUM_SRC and the
// set/clear action at bit WORD_W-1.
module irq_level_ctrl #(
    parameter int NUM_SRC = 14,
    parameter int WORD_W  = 16,
    parameter int LVL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_req_i,
    input  logic               req_wr_i,
    input  logic               en_wr_i,
    input  logic [WORD_W-1:0]  wr_data_i,
    output logic [WORD_W-1:0]  req_rd_o,
    output logic [LVL_W-1:0]   ipl_o
);
    localparam int MASTER_BIT = NUM_SRC;
    localparam int ACT_BIT    = WORD_W - 1;
    localparam int EN_W       = NUM_SRC + 1;

    logic [NUM_SRC-1:0] req_q;
    logic [EN_W-1:0]    en_q;
    logic [NUM_SRC-1:0] active;
    logic [LVL_W-1:0]   enc_level;

    irq_setclr_reg #(.W(NUM_SRC)) req_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (req_wr_i),
        .set_sel (wr_data_i[ACT_BIT]),
        .mask    (wr_data_i[NUM_SRC-1:0]),
        .hw_set  (hw_req_i),
        .q       (req_q)
    );

    irq_setclr_reg #(.W(EN_W)) en_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (en_wr_i),
        .set_sel (wr_data_i[ACT_BIT]),
        .mask    (wr_data_i[EN_W-1:0]),
        .hw_set  ('0),
        .q       (en_q)
    );

    // Sources that are both pending and individually enabled.
    assign active = req_q & en_q[NUM_SRC-1:0];

    irq_prio_enc #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) enc_i (
        .active (active),
        .level  (enc_level)
    );

    // Readback: the request register, zero-extended to the word width.
    assign req_rd_o = WORD_W'(req_q);

    // Registered level output, gated by the master enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                ipl_o <= '0;
        else if (en_q[MASTER_BIT]) ipl_o <= enc_level;
        else                       ipl_o <= '0;
    end

    AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[MASTER_BIT] |=> (ipl_o == '0)); // R9
    AST_NONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |=> (ipl_o == '0)); // R8
    AST_LVL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (active == $past(active) && en_q[MASTER_BIT] == $past(en_q[MASTER_BIT]))
        |=> $stable(ipl_o)); // R10
endmodule

// File: tb/irq_level_ctrl_tb.sv
// Bench irq_level_ctrl_tb_top: directed corner cases, then seeded random traffic,
// checked against a bench-side model of both registers and the level map.
module irq_level_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] hw_req_i = '0;
    logic        req_wr_i = 1'b0;
    logic        en_wr_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] req_rd_o;
    logic [2:0]  ipl_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [13:0] req_m = '0;
    logic [14:0] en_m  = '0;
    int          lvl_m = 0;

    irq_level_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .hw_req_i(hw_req_i), .req_wr_i(req_wr_i),
        .en_wr_i(en_wr_i), .wr_data_i(wr_data_i), .req_rd_o(req_rd_o), .ipl_o(ipl_o)
    );

    always #2 clk = ~clk;

    // Expected level computed from the requirement map (R7, R8, R9).
    function automatic int exp_lvl(input logic [13:0] r, input logic [14:0] e);
        logic [13:0] a;
        a = r & e[13:0];
        if (!e[14])        return 0;
        if (a[13])         return 6;
        if (|a[12:11])     return 5;
        if (|a[10:7])      return 4;
        if (|a[6:4])       return 3;
        if (a[3])          return 2;
        if (|a[2:0])       return 1;
        return 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: inputs already driven; update the model at the edge, sample at negedge.
    task automatic step();
        @(posedge clk);
        lvl_m = exp_lvl(req_m, en_m);
        if (req_wr_i) req_m = wr_data_i[15] ? (req_m | wr_data_i[13:0]) : (req_m & ~wr_data_i[13:0]);
        if (en_wr_i)  en_m  = wr_data_i[15] ? (en_m | wr_data_i[14:0]) : (en_m & ~wr_data_i[14:0]);
        req_m = req_m | hw_req_i;
        @(negedge clk);
        hw_req_i = '0; req_wr_i = 0; en_wr_i = 0; wr_data_i = '0;
    endtask

    task automatic wreq(input logic [15:0] d); req_wr_i = 1; wr_data_i = d; step(); endtask
    task automatic wen(input logic [15:0] d);  en_wr_i = 1;  wr_data_i = d; step(); endtask
    task automatic idle(); step(); endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset readback", req_rd_o, 0);
        check("R1 reset level", ipl_o, 0);

        // Enable everything, then verify each source alone (R7) and the one-cycle delay (R10).
        wen(16'hFFFF);
        for (int i = 0; i < 14; i++) begin
            wreq(16'h8000 | (16'h1 << i));
            check("R10 level not yet updated", ipl_o, 0);
            idle();
            check("R7 single source level", ipl_o, exp_lvl(14'h1 << i, 15'h7FFF));
            check("R2 set single bit", req_rd_o, 32'h1 << i);
            wreq(16'h0000 | (16'h1 << i));
            check("R3 cleared bit", req_rd_o, 0);
            idle();
        end

        // Highest level among several pending sources (R8).
        wreq(16'h8000 | 16'h0089);
        idle();
        check("R8 max of sources 0,3,7", ipl_o, 4);
        wreq(16'h0080);
        idle();
        check("R8 after removing source 7", ipl_o, 2);
        check("R3 unmarked bits kept", req_rd_o, 16'h0009);

        // Per-source enable clears (R4).
        wen(16'h0008);
        idle();
        check("R4 source 3 disabled", ipl_o, 1);

        // Master enable gates everything (R9).
        wen(16'h4000);
        idle();
        check("R9 master off level", ipl_o, 0);
        wen(16'hC008);
        idle();
        check("R4 master and source 3 back on", ipl_o, 2);

        // Hardware pulse wins over a same-cycle software clear (R5).
        hw_req_i = 14'h2000; req_wr_i = 1; wr_data_i = 16'h2000; step();
        check("R5 hw beats clear", req_rd_o[13], 1);
        idle();
        check("R5 level from hw source", ipl_o, 6);

        // Bit 14 of a request write has no visible effect; top bits read zero (R6).
        wreq(16'hC000);
        check("R6 upper bits zero", req_rd_o[15:14], 0);
        check("R6 lower bits unchanged", req_rd_o, 16'h2009);

        // Seeded random traffic against the model.
        for (int n = 0; n < 4000; n++) begin
            int k;
            k = $urandom % 8;
            if (k < 3)      begin req_wr_i = 1; wr_data_i = 16'($urandom); end
            else if (k < 5) begin en_wr_i = 1;  wr_data_i = 16'($urandom); end
            if ($urandom % 4 == 0) hw_req_i = 14'($urandom) & 14'($urandom) & 14'($urandom);
            step();
            check("R2 R3 R5 random readback", req_rd_o, {2'b00, req_m});
            check("R8 random level", ipl_o, lvl_m);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule